// File: doc/BRIEF.md
# Brainfuck Pointer and Cell Execution Datapath

This block carries out the four arithmetic commands of a processor whose machine code is the eight-character Brainfuck alphabet. Each clock cycle it receives one ASCII byte from a separate instruction store and turns it into a 3-bit command code. When it is enabled, it adds or subtracts one on either the 8-bit data pointer or the 8-bit cell that the pointer selects. A single incrementer/decrementer serves both targets. The code bits steer it directly, with no sequencing logic: bit 1 picks the target, bit 0 picks the direction, and bit 2 marks loop and I/O commands, which write nothing here.

A 32-bit program counter advances by one on every enabled cycle. The decoded code, a validity flag, the pointer and the selected cell value are exported so that loop and I/O logic built beside this block can act on them. The block has no state machine. Its only sequential elements are the program counter, the pointer register and the 256-cell bank.

Top module: `bfdp_core`

## Requirements
- R1: The eight command bytes decode combinationally, with `op_valid` = 1, as follows: 0x2B to 000, 0x2D to 001, 0x3E to 010, 0x3C to 011, 0x5B to 100, 0x5D to 101, 0x2E to 110 and 0x2C to 111.
- R2: Any other byte gives `op_valid` = 0 and `op_code` = 000. It changes neither the pointer nor any cell, and the program counter still advances.
- R3: Code 000 adds one to the selected cell at the rising edge, and 255 wraps to 0.
- R4: Code 001 subtracts one from the selected cell at the rising edge, and 0 wraps to 255.
- R5: Code 010 adds one to the pointer and code 011 subtracts one from it, wrapping between 255 and 0 in both directions.
- R6: Codes with bit 2 set (100 to 111) write neither the pointer nor any cell.
- R7: A pointer command leaves every cell unchanged. A cell command changes only the cell at the current pointer and leaves the pointer unchanged.
- R8: While `en` is 1, the program counter increments by one per cycle. While `en` is 0, the counter, the pointer and all cells hold.
- R9: A synchronous reset (`rst` = 1 at a rising edge) clears the program counter, the pointer and all 256 cells to zero.
- R10: `cell_val` shows, combinationally, the cell addressed by the current pointer, including a write made at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Execute the present byte and advance the program counter |
| instr_byte | input | 8 | ASCII command byte fetched at `pc` |
| pc | output | 32 | Program counter |
| op_code | output | 3 | Decoded command code |
| op_valid | output | 1 | Byte is one of the eight commands |
| cell_val | output | 8 | Cell selected by the pointer |
| ptr_val | output | 8 | Data pointer |

## Verification
`op_code` and `op_valid` depend only on `instr_byte`. They are due in the same cycle, so the bench reads them a nanosecond after it changes the byte, with `en` held low so that no state moves. The pointer, the cell value and the program counter each change at the first rising edge that samples `en` high, because exactly one register stands in each path. The bench therefore applies inputs on the falling edge and reads the results two nanoseconds after the following rising edge. It keeps its own model of the pointer, the cells it has touched and the counter, and compares against that model after every step.

// File: rtl/bfdp_pkg.sv
package bfdp_pkg;

    typedef enum logic [2:0] {
        OP_CELL_INC = 3'b000,
        OP_CELL_DEC = 3'b001,
        OP_PTR_INC  = 3'b010,
        OP_PTR_DEC  = 3'b011,
        OP_LOOP_IN  = 3'b100,
        OP_LOOP_OUT = 3'b101,
        OP_EMIT     = 3'b110,
        OP_FETCH    = 3'b111
    } bf_op_e;

    typedef struct packed {
        logic   valid;
        bf_op_e op;
    } bf_dec_t;

    // Bit positions inside the code that steer the datapath
    localparam int unsigned BIT_DIR = 0;  // 0: +1, 1: -1
    localparam int unsigned BIT_SEL = 1;  // 0: cell, 1: pointer
    localparam int unsigned BIT_ACT = 2;  // 1: loop or I/O, no write here

endpackage

// File: rtl/bfdp_decode.sv
module bfdp_decode
    import bfdp_pkg::*;
(
    input  logic [7:0] byte_in,
    output bf_dec_t    dec
);
    always_comb begin
        dec.valid = 1'b1;
        case (byte_in)
            8'h2B:   dec.op = OP_CELL_INC;
            8'h2D:   dec.op = OP_CELL_DEC;
            8'h3E:   dec.op = OP_PTR_INC;
            8'h3C:   dec.op = OP_PTR_DEC;
            8'h5B:   dec.op = OP_LOOP_IN;
            8'h5D:   dec.op = OP_LOOP_OUT;
            8'h2E:   dec.op = OP_EMIT;
            8'h2C:   dec.op = OP_FETCH;
            default: begin
                dec.valid = 1'b0;
                dec.op    = OP_CELL_INC;
            end
        endcase
    end
endmodule

// File: rtl/bfdp_step.sv
module bfdp_step #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cell_in,
    input  logic [W-1:0] ptr_in,
    input  logic         sel_ptr,
    input  logic         dir_down,
    output logic [W-1:0] result
);
    logic [W-1:0] operand;

    always_comb begin
        operand = sel_ptr ? ptr_in : cell_in;
        result  = dir_down ? operand - W'(1) : operand + W'(1);
    end
endmodule

// File: rtl/bfdp_store.sv
module bfdp_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cell_we,
    input  logic         ptr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ptr_q,
    output logic [W-1:0] cell_q
);
    localparam int unsigned DEPTH = 1 << W;

    logic [W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (ptr_we) ptr_q <= wdata;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                                bank[g] <= '0;
            else if (cell_we && ptr_q == W'(g))     bank[g] <= wdata;
        end
    end

    assign cell_q = bank[ptr_q];
endmodule

// File: rtl/bfdp_core.sv
module bfdp_core
    import bfdp_pkg::*;
#(
    parameter int unsigned PC_W = 32,
    parameter int unsigned W    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [7:0]      instr_byte,
    output logic [PC_W-1:0] pc,
    output logic [2:0]      op_code,
    output logic            op_valid,
    output logic [W-1:0]    cell_val,
    output logic [W-1:0]    ptr_val
);
    bf_dec_t      dec;
    logic [W-1:0] step_res;
    logic         wr_ok;
    logic         cell_we;
    logic         ptr_we;

    bfdp_decode u_dec (
        .byte_in (instr_byte),
        .dec     (dec)
    );

    bfdp_step #(.W(W)) u_step (
        .cell_in  (cell_val),
        .ptr_in   (ptr_val),
        .sel_ptr  (dec.op[BIT_SEL]),
        .dir_down (dec.op[BIT_DIR]),
        .result   (step_res)
    );

    always_comb begin
        wr_ok   = en & dec.valid & ~dec.op[BIT_ACT];
        cell_we = wr_ok & ~dec.op[BIT_SEL];
        ptr_we  = wr_ok &  dec.op[BIT_SEL];
    end

    bfdp_store #(.W(W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cell_we (cell_we),
        .ptr_we  (ptr_we),
        .wdata   (step_res),
        .ptr_q   (ptr_val),
        .cell_q  (cell_val)
    );

    always_ff @(posedge clk) begin
        if (rst)     pc <= '0;
        else if (en) pc <= pc + PC_W'(1);
    end

    assign op_code  = dec.op;
    assign op_valid = dec.valid;
endmodule

// File: rtl/bfdp_core_chk.sv
module bfdp_core_chk #(
    parameter int unsigned PC_W = 32,
    parameter int unsigned W    = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [7:0]      instr_byte,
    input logic [PC_W-1:0] pc,
    input logic [2:0]      op_code,
    input logic            op_valid,
    input logic [W-1:0]    cell_val,
    input logic [W-1:0]    ptr_val
);
    // R1
    loop_close_decode_chk: assert property (@(posedge clk) disable iff (rst)
        instr_byte == 8'h5D |-> op_valid && op_code == 3'b101);

    // R2
    junk_byte_chk: assert property (@(posedge clk) disable iff (rst)
        en && !op_valid |=> $stable(ptr_val) && $stable(cell_val));

    // R3
    cell_up_chk: assert property (@(posedge clk) disable iff (rst)
        en && instr_byte == 8'h2B |=> cell_val == W'($past(cell_val) + W'(1)) && $stable(ptr_val));

    // R4
    cell_down_chk: assert property (@(posedge clk) disable iff (rst)
        en && instr_byte == 8'h2D |=> cell_val == W'($past(cell_val) - W'(1)) && $stable(ptr_val));

    // R5
    ptr_up_chk: assert property (@(posedge clk) disable iff (rst)
        en && instr_byte == 8'h3E |=> ptr_val == W'($past(ptr_val) + W'(1)));

    // R6
    action_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        en && op_valid && op_code[2] |=> $stable(ptr_val) && $stable(cell_val));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> pc == PC_W'($past(pc) + PC_W'(1)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc) && $stable(ptr_val) && $stable(cell_val));
endmodule

bind bfdp_core bfdp_core_chk #(.PC_W(PC_W), .W(W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .instr_byte (instr_byte),
    .pc         (pc),
    .op_code    (op_code),
    .op_valid   (op_valid),
    .cell_val   (cell_val),
    .ptr_val    (ptr_val)
);

// File: tb/test_bfdp_core.sv
`timescale 1ns/1ps
module test_bfdp_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [7:0]  instr_byte;
    logic [31:0] pc;
    logic [2:0]  op_code;
    logic        op_valid;
    logic [7:0]  cell_val;
    logic [7:0]  ptr_val;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    bfdp_core i_bfdp_core (
        .clk(clk), .rst(rst), .en(en), .instr_byte(instr_byte),
        .pc(pc), .op_code(op_code), .op_valid(op_valid),
        .cell_val(cell_val), .ptr_val(ptr_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, read 2 ns after the next rising edge
    task automatic step(input logic [7:0] b, input logic e);
        @(negedge clk);
        instr_byte = b;
        en         = e;
        @(posedge clk);
        #2;
        if (e) exp_pc = exp_pc + 32'd1;
        en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; instr_byte = 8'h00;
        @(posedge clk); #2;
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 32'd0;
    endtask

    task automatic t_reset();
        check("R9 pc", pc, 32'd0);
        check("R9 ptr", {24'd0, ptr_val}, 32'd0);
        check("R9 cell", {24'd0, cell_val}, 32'd0);
    endtask

    task automatic t_decode();
        logic [7:0] chars [8] = '{8'h2B, 8'h2D, 8'h3E, 8'h3C, 8'h5B, 8'h5D, 8'h2E, 8'h2C};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            instr_byte = chars[i];
            en = 1'b0;
            #1;
            check("R1 code", {29'd0, op_code}, i);
            check("R1 valid", {31'd0, op_valid}, 32'd1);
        end
    endtask

    task automatic t_junk();
        logic [7:0] junk [4] = '{8'h00, 8'h41, 8'hFF, 8'h2A};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            instr_byte = junk[i];
            #1;
            check("R2 valid", {31'd0, op_valid}, 32'd0);
            check("R2 code", {29'd0, op_code}, 32'd0);
            step(junk[i], 1'b1);
            check("R2 ptr", {24'd0, ptr_val}, 32'd0);
            check("R2 cell", {24'd0, cell_val}, 32'd0);
            check("R2 pc", pc, exp_pc);
        end
    endtask

    task automatic t_cell_ops();
        for (int i = 0; i < 3; i++) step(8'h2B, 1'b1);
        check("R3 cell up", {24'd0, cell_val}, 32'd3);
        check("R7 ptr kept", {24'd0, ptr_val}, 32'd0);
        step(8'h3E, 1'b1);
        check("R5 ptr up", {24'd0, ptr_val}, 32'd1);
        check("R10 new cell", {24'd0, cell_val}, 32'd0);
        step(8'h2D, 1'b1);
        check("R4 wrap down", {24'd0, cell_val}, 32'd255);
        step(8'h2B, 1'b1);
        check("R3 wrap up", {24'd0, cell_val}, 32'd0);
        step(8'h2D, 1'b1);
        step(8'h3C, 1'b1);
        check("R5 ptr down", {24'd0, ptr_val}, 32'd0);
        check("R7 cell 0 intact", {24'd0, cell_val}, 32'd3);
        step(8'h3C, 1'b1);
        check("R5 wrap down", {24'd0, ptr_val}, 32'd255);
        check("R7 cell 255", {24'd0, cell_val}, 32'd0);
        step(8'h3E, 1'b1);
        check("R5 wrap up", {24'd0, ptr_val}, 32'd0);
        step(8'h3E, 1'b1);
        check("R7 cell 1", {24'd0, cell_val}, 32'd255);
        check("R8 pc", pc, exp_pc);
    endtask

    task automatic t_action();
        logic [7:0] acts [4] = '{8'h5B, 8'h5D, 8'h2E, 8'h2C};
        for (int i = 0; i < 4; i++) begin
            step(acts[i], 1'b1);
            check("R6 ptr", {24'd0, ptr_val}, 32'd1);
            check("R6 cell", {24'd0, cell_val}, 32'd255);
        end
        check("R6 pc", pc, exp_pc);
    endtask

    task automatic t_idle();
        step(8'h2B, 1'b0);
        step(8'h3E, 1'b0);
        check("R8 idle pc", pc, exp_pc);
        check("R8 idle ptr", {24'd0, ptr_val}, 32'd1);
        check("R8 idle cell", {24'd0, cell_val}, 32'd255);
    endtask

    task automatic t_reset_mid();
        do_reset();
        t_reset();
        step(8'h3E, 1'b1);
        check("R9 cell 1 cleared", {24'd0, cell_val}, 32'd0);
        check("R8 pc after reset", pc, 32'd1);
    endtask

    initial begin
        #200_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        exp_pc = 32'd0;
        rst = 1'b1; en = 1'b0; instr_byte = 8'h00;
        repeat (2) @(posedge clk);
        do_reset();
        t_reset();
        t_decode();
        t_junk();
        t_cell_ops();
        t_action();
        t_idle();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule